// File: doc/BRIEF.md
# Pipelined Store Tag-Check Unit

This block is the store path of a small direct-mapped, write-through data cache. Each store is split over two stages. In the first stage the store's tag is compared with the cache tag. In the second stage its data is written into the data array. The tag comparison of one store happens in the same clock edge as the array write of the store before it, so a store hit costs the CPU a single cycle.

Between the two stages sits a one-entry delayed write buffer. It holds a store that has passed its tag check and has not yet been written. The entry stays there until the next store hit, or until any miss, pushes it into the array. A load compares its word address with the buffered entry and overlays the buffered bytes on the array word, so it always sees the newest value.

A miss is handed to the next level through a request/acknowledge port, and the CPU stalls until the acknowledge arrives. A store miss goes down with its data and does not allocate a line. A load miss installs the word that comes back and returns it to the CPU. Stores that hit are also sent on to memory, by a write-through path outside this block.

Top module: `store_tagcheck_pipe`

## Requirements
- R1: After reset the write buffer is empty and every cache line is invalid, so the first load to any address misses. After reset reqReady=1, missValid=0 and rspValid=0.
- R2: The word address is split into a line index (its low log2(LINES) bits) and a tag (the remaining bits). A store whose index selects a valid line with an equal tag is accepted in one cycle. It raises no miss request and gives no response, and it is placed in the write buffer.
- R3: A load that hits gives rspValid=1 in the cycle after it is accepted, with the stored word of its line on rspData.
- R4: A load whose word address equals the buffered store's address returns the buffered bytes wherever the buffer's byte enable is set, and the array bytes elsewhere.
- R5: When a store hit is accepted while the buffer holds an entry, the held entry is written into the data array at the same clock edge, and the new store takes its place.
- R6: A store miss gives, in the next cycle, missValid=1 and missWrite=1, with the store's address, data and byte enables on the miss port. These outputs hold and reqReady stays 0 until the cycle after missAck. No cache line is allocated or changed.
- R7: A load miss gives missValid=1 and missWrite=0 with its address. On missAck the missData word is installed as the line, and rspValid=1 with that word follows in the next cycle. Later loads to that address hit.
- R8: Any miss writes a held store into the array in the cycle the miss is detected, so the buffer is empty while a miss is outstanding. A store held before a miss never lands in a line that the miss refilled.
- R9: Loads and cycles with no request leave a buffered store pending and intact. Later loads still see its bytes.
- R10: Byte enable bit k covers data bits 8k+7 down to 8k. Bytes whose enable is 0 keep their previous value.
- R11: A store never causes rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | CPU request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| reqBe | input | DATA_W/8 | Store byte enables |
| reqReady | output | 1 | Request is accepted this cycle when high |
| rspValid | output | 1 | Load data valid |
| rspData | output | DATA_W | Load data |
| missValid | output | 1 | Miss request outstanding |
| missWrite | output | 1 | Miss is a store |
| missAddr | output | ADDR_W | Miss word address |
| missWdata | output | DATA_W | Store data of a store miss |
| missBe | output | DATA_W/8 | Byte enables of a store miss |
| missAck | input | 1 | Next level completes the outstanding miss |
| missData | input | DATA_W | Word returned for a load miss |

## Verification
The buffer is visible only through loads, so a wrong buffer state shows up on rspData in the cycle after the first load to the affected word. The errors this catches are a lost merge, a missing retirement into the array, and an entry that survives a miss. That last error is caught by storing to a line, replacing the line with a load miss, and then forcing a retirement with a store elsewhere. A wrong miss state shows up on reqReady and on the miss port in the cycle after the failing request, or in the cycle after missAck, where the refilled word must come back on rspData.

// File: rtl/stp_pkg.sv
package stp_pkg;

  // Strobes issued by the control toward the datapath for one cycle.
  typedef struct packed {
    logic bufPush;      // store hit: load request into the write buffer
    logic bufDrain;     // retire the held entry into the data array
    logic missCapture;  // register the request on the miss port
    logic fillLine;     // install returned word for a load miss
    logic rspHit;       // respond with merged array/buffer word
    logic rspFill;      // respond with returned word
  } ctlStrobes_t;

endpackage

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import stp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        lookupHit,
  input  logic        bufValid,
  input  logic        missAck,
  output logic        missPending,
  output logic        reqReady,
  output ctlStrobes_t ctl
);

  logic missIsLoad;
  logic accept;

  assign accept   = reqValid && !missPending;
  assign reqReady = !missPending;

  always_comb begin
    ctl = '0;
    if (missPending) begin
      if (missAck) begin
        ctl.fillLine = missIsLoad;
        ctl.rspFill  = missIsLoad;
      end
    end else if (accept) begin
      if (lookupHit) begin
        if (reqWrite) begin
          ctl.bufPush  = 1'b1;
          ctl.bufDrain = bufValid;
        end else begin
          ctl.rspHit = 1'b1;
        end
      end else begin
        ctl.missCapture = 1'b1;
        ctl.bufDrain    = bufValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      missPending <= 1'b0;
      missIsLoad  <= 1'b0;
    end else if (ctl.missCapture) begin
      missPending <= 1'b1;
      missIsLoad  <= !reqWrite;
    end else if (missPending && missAck) begin
      missPending <= 1'b0;
    end
  end

endmodule

// File: rtl/stp_datapath.sv
module stp_datapath
  import stp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         ctl,
  input  logic                missBusy,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0]   missData,
  output logic                lookupHit,
  output logic                bufValid,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                missWrite,
  output logic [ADDR_W-1:0]   missAddr,
  output logic [DATA_W-1:0]   missWdata,
  output logic [DATA_W/8-1:0] missBe
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int BYTES = DATA_W / 8;

  logic [LINES-1:0]  lineValid;
  logic [TAG_W-1:0]  lineTag [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;
  logic [BYTES-1:0]  bufBe;

  logic [IDX_W-1:0]  reqIdx, bufIdx, missIdx;
  logic [TAG_W-1:0]  reqTag, bufTag, missTag;
  logic              bufMatch;
  logic [DATA_W-1:0] loadWord, drainWord;

  assign reqIdx  = reqAddr[IDX_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:IDX_W];
  assign bufIdx  = bufAddr[IDX_W-1:0];
  assign bufTag  = bufAddr[ADDR_W-1:IDX_W];
  assign missIdx = missAddr[IDX_W-1:0];
  assign missTag = missAddr[ADDR_W-1:IDX_W];

  assign lookupHit = lineValid[reqIdx] && (lineTag[reqIdx] == reqTag);
  assign bufMatch  = bufValid && (bufAddr == reqAddr);

  // Load forwarding and retirement merge, byte by byte.
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      loadWord[b*8 +: 8]  = (bufMatch && bufBe[b]) ? bufData[b*8 +: 8]
                                                    : dataArr[reqIdx][b*8 +: 8];
      drainWord[b*8 +: 8] = bufBe[b] ? bufData[b*8 +: 8]
                                     : dataArr[bufIdx][b*8 +: 8];
    end
  end

  // Arrays without reset: contents qualified by lineValid.
  always_ff @(posedge clk) begin
    if (ctl.bufDrain) begin
      dataArr[bufIdx] <= drainWord;
    end else if (ctl.fillLine) begin
      dataArr[missIdx] <= missData;
      lineTag[missIdx] <= missTag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineValid <= '0;
      bufValid  <= 1'b0;
      bufAddr   <= '0;
      bufData   <= '0;
      bufBe     <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
      missWrite <= 1'b0;
      missAddr  <= '0;
      missWdata <= '0;
      missBe    <= '0;
    end else begin
      if (ctl.bufPush) begin
        bufValid <= 1'b1;
        bufAddr  <= reqAddr;
        bufData  <= reqWdata;
        bufBe    <= reqBe;
      end else if (ctl.bufDrain) begin
        bufValid <= 1'b0;
      end
      if (ctl.fillLine) lineValid[missIdx] <= 1'b1;
      rspValid <= ctl.rspHit || ctl.rspFill;
      if (ctl.rspHit)       rspData <= loadWord;
      else if (ctl.rspFill) rspData <= missData;
      if (ctl.missCapture) begin
        missWrite <= reqWrite;
        missAddr  <= reqAddr;
        missWdata <= reqWdata;
        missBe    <= reqBe;
      end
    end
  end

  // A held store always targets a present line with its own tag.
  assert_buf_in_line_R5: assert property (@(posedge clk) disable iff (rst)
    bufValid |-> (lineValid[bufIdx] && (lineTag[bufIdx] == bufTag)));

  // Write pipeline is empty while a miss is outstanding.
  assert_pipe_empty_in_miss_R8: assert property (@(posedge clk) disable iff (rst)
    missBusy |-> !bufValid);

endmodule

// File: rtl/store_tagcheck_pipe.sv
module store_tagcheck_pipe
  import stp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                missValid,
  output logic                missWrite,
  output logic [ADDR_W-1:0]   missAddr,
  output logic [DATA_W-1:0]   missWdata,
  output logic [DATA_W/8-1:0] missBe,
  input  logic                missAck,
  input  logic [DATA_W-1:0]   missData
);

  ctlStrobes_t ctl;
  logic        lookupHit;
  logic        bufValid;

  stp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .lookupHit  (lookupHit),
    .bufValid   (bufValid),
    .missAck    (missAck),
    .missPending(missValid),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  stp_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .missBusy (missValid),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .missData (missData),
    .lookupHit(lookupHit),
    .bufValid (bufValid),
    .rspValid (rspValid),
    .rspData  (rspData),
    .missWrite(missWrite),
    .missAddr (missAddr),
    .missWdata(missWdata),
    .missBe   (missBe)
  );

  // Miss request holds its contents until acknowledged.
  assert_miss_held_R6: assert property (@(posedge clk) disable iff (rst)
    (missValid && !missAck) |=> (missValid && $stable(missAddr) &&
                                 $stable(missWrite) && $stable(missWdata)));

  // Stores never answer on the response port.
  assert_store_silent_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reqValid && reqReady && reqWrite) |-> !rspValid);

  // A response follows an accepted load or an acknowledged miss.
  assert_rsp_cause_R3: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> ($past(reqValid && reqReady && !reqWrite) ||
                  $past(missValid && missAck)));

endmodule

// File: tb/tb_store_tagcheck_pipe.sv
`timescale 1ns/1ps
module tb_store_tagcheck_pipe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        reqReady, rspValid, missValid, missWrite;
  logic [31:0] rspData, missWdata;
  logic [11:0] missAddr;
  logic [3:0]  missBe;
  logic        missAck = 1'b0;
  logic [31:0] missData = '0;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  store_tagcheck_pipe dut (.*);

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;   // store data, or fill word for a load miss
    logic [3:0]  be;
    logic        miss;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  // A=0x013 (idx 3), B=0x024 (idx 4), C=0x053 (idx 3, other tag)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h013, 32'h11112222, 4'h0, 1'b1, 32'h11112222},
    '{1'b0, 12'h013, 32'h0,        4'h0, 1'b0, 32'h11112222},
    '{1'b1, 12'h013, 32'hAABBCCDD, 4'h3, 1'b0, 32'h0},
    '{1'b0, 12'h013, 32'h0,        4'h0, 1'b0, 32'h1111CCDD},
    '{1'b0, 12'h024, 32'h33334444, 4'h0, 1'b1, 32'h33334444},
    '{1'b0, 12'h013, 32'h0,        4'h0, 1'b0, 32'h1111CCDD},
    '{1'b1, 12'h013, 32'h55667788, 4'hC, 1'b0, 32'h0},
    '{1'b1, 12'h024, 32'h99990000, 4'hF, 1'b0, 32'h0},
    '{1'b0, 12'h013, 32'h0,        4'h0, 1'b0, 32'h5566CCDD},
    '{1'b0, 12'h024, 32'h0,        4'h0, 1'b0, 32'h99990000},
    '{1'b1, 12'h053, 32'hDEAD0000, 4'hF, 1'b1, 32'h0},
    '{1'b0, 12'h053, 32'h0C0C0C0C, 4'h0, 1'b1, 32'h0C0C0C0C},
    '{1'b0, 12'h053, 32'h0,        4'h0, 1'b0, 32'h0C0C0C0C},
    '{1'b0, 12'h024, 32'h0,        4'h0, 1'b0, 32'h99990000},
    '{1'b0, 12'h013, 32'h77777777, 4'h0, 1'b1, 32'h77777777},
    '{1'b1, 12'h013, 32'h000000FF, 4'h1, 1'b0, 32'h0},
    '{1'b0, 12'h013, 32'h0,        4'h0, 1'b0, 32'h777777FF},
    '{1'b0, 12'h053, 32'h12345678, 4'h0, 1'b1, 32'h12345678},
    '{1'b1, 12'h024, 32'h00000001, 4'h1, 1'b0, 32'h0},
    '{1'b0, 12'h053, 32'h0,        4'h0, 1'b0, 32'h12345678},
    '{1'b0, 12'h024, 32'h0,        4'h0, 1'b0, 32'h99990001}
  };
  localparam string VTAG [NV] = '{
    "R7", "R3", "R2", "R4", "R7", "R8", "R10", "R5", "R5", "R4", "R6",
    "R6", "R3", "R8", "R7", "R2", "R4", "R8", "R8", "R8", "R4"
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic ackMiss(input logic [31:0] fill);
    missAck = 1'b1; missData = fill;
    @(negedge clk);
    missAck = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input string tag);
    issue(v.wr, v.addr, v.data, v.be);
    if (v.miss) begin
      chk({tag, " miss raised"}, 32'(missValid), 32'd1);
      chk({tag, " miss kind"}, 32'(missWrite), 32'(v.wr));
      chk({tag, " miss addr"}, 32'(missAddr), 32'(v.addr));
      chk({tag, " stalled"}, 32'(reqReady), 32'd0);
      if (v.wr) begin
        chk({tag, " miss data"}, missWdata, v.data);
        chk({tag, " miss be"}, 32'(missBe), 32'(v.be));
      end
      ackMiss(v.data);
      chk({tag, " ready after ack"}, 32'(reqReady), 32'd1);
      chk({tag, " miss cleared"}, 32'(missValid), 32'd0);
    end else begin
      chk({tag, " no miss"}, 32'(missValid), 32'd0);
    end
    if (v.wr) begin
      chk({tag, " R11 store silent"}, 32'(rspValid), 32'd0);
    end else begin
      chk({tag, " rsp valid"}, 32'(rspValid), 32'd1);
      chk({tag, " rsp data"}, rspData, v.exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 ready", 32'(reqReady), 32'd1);
    chk("R1 miss", 32'(missValid), 32'd0);
    chk("R1 rsp", 32'(rspValid), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], VTAG[i]);

    // R9: store hit, idle cycles and loads leave the buffer intact.
    issue(1'b1, 12'h024, 32'hABCD0000, 4'hC);   // retires B byte0=01
    repeat (4) @(negedge clk);
    issue(1'b0, 12'h053, 32'h0, 4'h0);
    chk("R9 other load", rspData, 32'h12345678);
    repeat (2) @(negedge clk);
    issue(1'b0, 12'h024, 32'h0, 4'h0);
    chk("R9 pending store seen", rspData, 32'hABCD0001);

    // R6 stall: request held while the miss waits is not accepted.
    issue(1'b0, 12'h0A5, 32'h0, 4'h0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 12'h0A5; reqWdata = 32'h0; reqBe = 4'hF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 stall ready", 32'(reqReady), 32'd0);
      chk("R6 stall miss held", 32'(missValid), 32'd1);
      chk("R6 stall addr", 32'(missAddr), 32'h0A5);
      chk("R6 stall no rsp", 32'(rspValid), 32'd0);
    end
    reqValid = 1'b0;
    ackMiss(32'hCAFEF00D);
    chk("R7 fill rsp valid", 32'(rspValid), 32'd1);
    chk("R7 fill rsp", rspData, 32'hCAFEF00D);
    issue(1'b0, 12'h0A5, 32'h0, 4'h0);
    chk("R7 later hit no miss", 32'(missValid), 32'd0);
    chk("R6 stalled store dropped", rspData, 32'hCAFEF00D);

    // R1: reset mid-run invalidates lines and empties the buffer.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    issue(1'b0, 12'h024, 32'h0, 4'h0);
    chk("R1 line invalid after reset", 32'(missValid), 32'd1);
    ackMiss(32'h00000042);
    chk("R1 fill after reset", rspData, 32'h00000042);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule